// File: doc/BRIEF.md
# Output Fault Supervisor with Power-Good

This block watches the state of a switching regulator's output and decides when the output is good, when a fault must stop the converter, and how the power stage is to be driven while a fault is handled. It receives already-digitised comparator flags (feedback above 95 %, below 70 %, above 125 % and above 105 % of the reference), an over-temperature flag, a start-up-complete flag, an enable and a supply-good flag. From these it produces a power-good indication, a latched-fault indication, a command that forces the low-side switch on, a soft-stop discharge enable and a switching inhibit.

Each out-of-range flag passes through a counter-based glitch filter whose length is a parameter in clock cycles. Under-voltage and over-voltage latch a fault. Over-voltage clamps the output by holding the low side on only until feedback falls under 105 %, after which both switches stay off. Over-temperature does not latch: it inhibits switching while present and the output must qualify as good again afterwards. Latched faults clear only when enable or supply-good goes low.

Top module: `outfault_sup`

## Requirements
- R1: After reset with enable and supply-good high and all flags low, power-good, fault and force-low-side are 0, and inhibit and discharge are 0.
- R2: While active with no fault and no over-temperature, power-good goes to 1 one clock after the above-95 % flag is sampled high.
- R3: Power-good drops one clock after the below-70 % or above-125 % flag has been sampled high on PG_LEN consecutive edges; a shorter pulse leaves it at 1, and with feedback between 70 % and 95 % (all flags low) it holds at 1.
- R4: A below-70 % flag sampled high on UV_LEN consecutive edges latches the fault one clock later only when start-up-complete is 1; before start-up completes it latches nothing.
- R5: An above-125 % flag sampled high on OV_LEN consecutive edges sets the force-low-side command, the latched fault and the inhibit one clock later, with discharge held at 0 while the force is on.
- R6: Once the above-105 % flag is sampled low, the force-low-side command is released on that edge; the fault and inhibit stay at 1 and discharge rises to 1.
- R7: Enable or supply-good sampled low clears every latched fault and the force command on that edge; while either is low, inhibit and discharge are 1 and power-good is 0.
- R8: The over-temperature flag sets inhibit and discharge one clock after it is sampled high and drops power-good, without latching; after it clears, inhibit and discharge return to 0 and power-good stays 0 until the above-95 % flag is seen again.
- R9: While a fault is latched, power-good stays 0 whatever the feedback flags show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable |
| supply_ok_i | input | 1 | Supply above power-on threshold |
| fb_above95_i | input | 1 | Feedback above 95 % of reference |
| fb_below70_i | input | 1 | Feedback below 70 % of reference |
| fb_above125_i | input | 1 | Feedback above 125 % of reference |
| fb_above105_i | input | 1 | Feedback above 105 % of reference |
| overtemp_i | input | 1 | Die temperature too high (hysteresis outside) |
| startup_done_i | input | 1 | Soft-start ramp finished |
| pgood_o | output | 1 | Output regulation good |
| fault_o | output | 1 | Under- or over-voltage fault latched |
| force_low_o | output | 1 | Hold low-side switch on (over-voltage clamp) |
| discharge_o | output | 1 | Soft-stop discharge enable |
| inhibit_o | output | 1 | Stop switching, both gates low |

## Verification
Under-voltage is driven both before and after start-up completes, which separates the start-up mask from the filter itself, and pulses one cycle shorter than each filter length show that glitches are rejected. The over-voltage sequence holds the 105 % flag high and then drops it, telling apart the clamp phase from the released, still-latched phase. Faults are cleared once through enable and once through supply-good, and over-temperature is cleared with the 95 % flag low, which shows that it neither latches nor lets power-good come back without a new qualification.

// File: rtl/outfault_sup_pkg.sv
package outfault_sup_pkg;

    typedef struct packed {
        logic pgood;
        logic uv_lat;
        logic ov_lat;
        logic force_low;
        logic overtemp;
    } sup_state_t;

    localparam sup_state_t SUP_IDLE = '{default: 1'b0};

    typedef enum logic [1:0] {
        FLT_UV   = 2'd0,
        FLT_OV   = 2'd1,
        FLT_PGLO = 2'd2,
        FLT_PGHI = 2'd3
    } flt_idx_e;

    localparam int NUM_FLT = 4;

endpackage

// File: rtl/outfault_glitch_filt.sv
module outfault_glitch_filt #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic flag_i,
    output logic qual_o
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LIM = CW'(LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          qual_d, qual_q;

    always_comb begin
        cnt_d  = cnt_q;
        qual_d = 1'b0;
        if (clr_i || !flag_i) begin
            cnt_d = '0;
        end else begin
            qual_d = (cnt_q >= LIM);
            if (cnt_q < LIM) cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            qual_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            qual_q <= qual_d;
        end
    end

    assign qual_o = qual_q;

    // R3 R4 R5: a qualified flag was high on the edge that produced it
    a_r3_qual_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        qual_q |-> $past(flag_i));

    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);

endmodule

// File: rtl/outfault_sup_ctrl.sv
module outfault_sup_ctrl
    import outfault_sup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic fb_above95_i,
    input  logic fb_above105_i,
    input  logic overtemp_i,
    input  logic startup_done_i,
    input  logic uv_qual_i,
    input  logic ov_qual_i,
    input  logic pglo_qual_i,
    input  logic pghi_qual_i,
    output logic pgood_o,
    output logic fault_o,
    output logic force_low_o,
    output logic discharge_o,
    output logic inhibit_o
);
    sup_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active_i) begin
            st_d = SUP_IDLE;
        end else begin
            st_d.uv_lat   = st_q.uv_lat | (uv_qual_i & startup_done_i);
            st_d.ov_lat   = st_q.ov_lat | ov_qual_i;
            if (ov_qual_i)
                st_d.force_low = 1'b1;
            else if (!fb_above105_i)
                st_d.force_low = 1'b0;
            st_d.overtemp = overtemp_i;
            st_d.pgood    = !st_d.uv_lat && !st_d.ov_lat && !overtemp_i
                         && !pglo_qual_i && !pghi_qual_i
                         && (st_q.pgood || fb_above95_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SUP_IDLE;
        else        st_q <= st_d;
    end

    logic fault_any;
    assign fault_any   = st_q.uv_lat | st_q.ov_lat;
    assign pgood_o     = st_q.pgood;
    assign fault_o     = fault_any;
    assign force_low_o = st_q.force_low;
    assign inhibit_o   = !active_i | fault_any | st_q.overtemp;
    assign discharge_o = !active_i | st_q.uv_lat | st_q.overtemp
                       | (st_q.ov_lat & !st_q.force_low);

    // R9: no power-good while a fault is held
    a_r9_pg_low_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !pgood_o);

    // R5: the clamp only exists alongside a latched over-voltage
    a_r5_force_has_fault: assert property (@(posedge clk) disable iff (!rst_n)
        force_low_o |-> st_q.ov_lat);

    // R4: under-voltage latches only after start-up
    a_r4_uv_after_startup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.uv_lat) |-> $past(startup_done_i));

    // R6: clamp release follows feedback dropping below 105 %
    a_r6_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.force_low) && $past(active_i)) |-> !$past(fb_above105_i));

    // R7: inactive cycle wipes all latched state
    a_r7_clear_on_off: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (!st_q.uv_lat && !st_q.ov_lat && !st_q.force_low));

    // R8: over-temperature never latches a fault by itself
    a_r8_ot_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> ($past(uv_qual_i) || $past(ov_qual_i)));

endmodule

// File: rtl/outfault_sup.sv
module outfault_sup
    import outfault_sup_pkg::*;
#(
    parameter int UV_LEN = 4,
    parameter int OV_LEN = 4,
    parameter int PG_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic supply_ok_i,
    input  logic fb_above95_i,
    input  logic fb_below70_i,
    input  logic fb_above125_i,
    input  logic fb_above105_i,
    input  logic overtemp_i,
    input  logic startup_done_i,
    output logic pgood_o,
    output logic fault_o,
    output logic force_low_o,
    output logic discharge_o,
    output logic inhibit_o
);
    logic active;
    logic [NUM_FLT-1:0] raw_flag;
    logic [NUM_FLT-1:0] qual_flag;

    assign active = en_i & supply_ok_i;

    assign raw_flag[FLT_UV]   = fb_below70_i;
    assign raw_flag[FLT_OV]   = fb_above125_i;
    assign raw_flag[FLT_PGLO] = fb_below70_i;
    assign raw_flag[FLT_PGHI] = fb_above125_i;

    for (genvar gi = 0; gi < NUM_FLT; gi++) begin : g_filt
        localparam int FLEN = (gi == int'(FLT_UV)) ? UV_LEN :
                              (gi == int'(FLT_OV)) ? OV_LEN : PG_LEN;
        outfault_glitch_filt #(.LEN(FLEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (!active),
            .flag_i (raw_flag[gi]),
            .qual_o (qual_flag[gi])
        );
    end

    outfault_sup_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .active_i       (active),
        .fb_above95_i   (fb_above95_i),
        .fb_above105_i  (fb_above105_i),
        .overtemp_i     (overtemp_i),
        .startup_done_i (startup_done_i),
        .uv_qual_i      (qual_flag[FLT_UV]),
        .ov_qual_i      (qual_flag[FLT_OV]),
        .pglo_qual_i    (qual_flag[FLT_PGLO]),
        .pghi_qual_i    (qual_flag[FLT_PGHI]),
        .pgood_o        (pgood_o),
        .fault_o        (fault_o),
        .force_low_o    (force_low_o),
        .discharge_o    (discharge_o),
        .inhibit_o      (inhibit_o)
    );

endmodule

// File: tb/outfault_sup_tb.sv
module outfault_sup_tb;
    localparam int CLK_PERIOD = 10;
    localparam int UV_LEN = 4;
    localparam int OV_LEN = 4;
    localparam int PG_LEN = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1, sup = 1'b1;
    logic a95 = 0, b70 = 0, a125 = 0, a105 = 0, ot = 0, done = 0;
    logic pgood, fault, force_low, discharge, inhibit;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    outfault_sup #(.UV_LEN(UV_LEN), .OV_LEN(OV_LEN), .PG_LEN(PG_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .supply_ok_i(sup),
        .fb_above95_i(a95), .fb_below70_i(b70), .fb_above125_i(a125),
        .fb_above105_i(a105), .overtemp_i(ot), .startup_done_i(done),
        .pgood_o(pgood), .fault_o(fault), .force_low_o(force_low),
        .discharge_o(discharge), .inhibit_o(inhibit)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic qualify_good();
        a95 = 1; step(1);
        chk("R2", "pgood after 95% seen", pgood, 1'b1);
        a95 = 0;
    endtask

    task automatic t_reset();
        chk("R1", "pgood", pgood, 1'b0);
        chk("R1", "fault", fault, 1'b0);
        chk("R1", "force", force_low, 1'b0);
        chk("R1", "inhibit", inhibit, 1'b0);
        chk("R1", "discharge", discharge, 1'b0);
    endtask

    task automatic t_pg_window();
        qualify_good();
        step(3);
        chk("R3", "pgood holds between 70 and 95", pgood, 1'b1);
        b70 = 1; done = 0;
        step(UV_LEN + 1);
        chk("R4", "no uv latch before start-up", fault, 1'b0);
        chk("R3", "pgood before pg filter expires", pgood, 1'b1);
        step(PG_LEN - UV_LEN);
        chk("R3", "pgood drop after below-70 filter", pgood, 1'b0);
        chk("R4", "still no fault", fault, 1'b0);
        b70 = 0; step(1);
        qualify_good();
        a125 = 1; a105 = 1;
        step(OV_LEN - 1);
        a125 = 0; a105 = 0; step(2);
        chk("R3", "short above-125 pulse ignored by pgood", pgood, 1'b1);
        chk("R5", "short above-125 pulse no force", force_low, 1'b0);
    endtask

    task automatic t_uv();
        done = 1;
        b70 = 1; step(UV_LEN - 1); b70 = 0; step(2);
        chk("R4", "short uv pulse no fault", fault, 1'b0);
        chk("R3", "short uv pulse pgood kept", pgood, 1'b1);
        b70 = 1; step(UV_LEN);
        chk("R4", "uv not yet latched", fault, 1'b0);
        step(1);
        chk("R4", "uv latched", fault, 1'b1);
        chk("R4", "uv discharge", discharge, 1'b1);
        chk("R4", "uv inhibit", inhibit, 1'b1);
        chk("R9", "pgood low at uv", pgood, 1'b0);
        b70 = 0; a95 = 1; step(3);
        chk("R9", "pgood held low with fault", pgood, 1'b0);
        chk("R9", "fault stays latched", fault, 1'b1);
        a95 = 0; en = 0; step(1);
        chk("R7", "enable low clears fault", fault, 1'b0);
        chk("R7", "off inhibit", inhibit, 1'b1);
        chk("R7", "off discharge", discharge, 1'b1);
        chk("R7", "off pgood", pgood, 1'b0);
        en = 1; step(1);
        chk("R7", "back on, inhibit released", inhibit, 1'b0);
    endtask

    task automatic t_ov();
        qualify_good();
        a125 = 1; a105 = 1;
        step(OV_LEN);
        chk("R5", "force not yet", force_low, 1'b0);
        step(1);
        chk("R5", "force on", force_low, 1'b1);
        chk("R5", "fault on", fault, 1'b1);
        chk("R5", "inhibit on", inhibit, 1'b1);
        chk("R5", "no discharge during clamp", discharge, 1'b0);
        chk("R9", "pgood low at ov", pgood, 1'b0);
        a125 = 0; step(2);
        chk("R6", "force held above 105", force_low, 1'b1);
        a105 = 0; step(1);
        chk("R6", "force released", force_low, 1'b0);
        chk("R6", "fault kept", fault, 1'b1);
        chk("R6", "inhibit kept", inhibit, 1'b1);
        chk("R6", "discharge after release", discharge, 1'b1);
        sup = 0; step(1);
        chk("R7", "supply low clears fault", fault, 1'b0);
        sup = 1; step(1);
        chk("R7", "fault stays clear", fault, 1'b0);
    endtask

    task automatic t_ot();
        qualify_good();
        ot = 1; step(1);
        chk("R8", "ot inhibit", inhibit, 1'b1);
        chk("R8", "ot discharge", discharge, 1'b1);
        chk("R8", "ot pgood low", pgood, 1'b0);
        chk("R8", "ot no fault", fault, 1'b0);
        ot = 0; step(1);
        chk("R8", "ot cleared inhibit", inhibit, 1'b0);
        chk("R8", "ot cleared discharge", discharge, 1'b0);
        step(2);
        chk("R8", "pgood waits for 95%", pgood, 1'b0);
        qualify_good();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_pg_window();
        t_uv();
        t_ov();
        t_ot();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule